// File: doc/BRIEF.md
# Bus Stall and Single-Step Controller

This block sits between the cycle sequencer of a small 8-bit processor core and its external bus. Each bus cycle is split into a first phase and a second phase, both modelled as enables on one clock. The core presents a cycle type and an address. The block registers them onto the bus and raises a fetch indicator on opcode fetches. It also gates the enable of the tri-state data output driver.

The block samples an external ready input at one fixed clock inside the second phase. If ready is low during a read or fetch cycle, a registered stall output freezes the core. The same bus cycle then repeats, with the same address and read strobe, until ready is seen high. Write cycles never stall. A low ready during a write therefore takes effect at the next read.

Outside logic can step through a program one instruction at a time. It pulls ready low whenever the fetch indicator is high, and releases it for one sample to run the next instruction. The core sees one advance strobe at the end of each completed cycle.

Top module: `bus_stall_ctl`

## Requirements
- R1: While rst_ni is low, stall_o, adv_o, fetch_o and drv_en_o are 0, rd_o is 1, addr_o is 0 and ph1_o is 1.
- R2: The phase outputs alternate: ph1_o is high for PH1_LEN clocks, then ph2_o is high for PH2_LEN clocks. adv_o is high for at most one clock per cycle, on the last clock of phase two.
- R3: Cycle type codes are 2'b00 read, 2'b01 opcode fetch, 2'b10 write and 2'b11 dummy read. If ready_i is 0 at the sample clock (phase-two clock RDY_TICK) of any non-write cycle, stall_o is 1 from the next clock, no adv_o is given, and the core's cycle does not advance.
- R4: A stalled cycle is released at the first sample clock that sees rdy_i high. stall_o drops on the next clock, and adv_o fires on the last clock of that same cycle.
- R5: rdy_i has no effect during a write cycle (type 2'b10): the cycle completes. A ready still low at the next read's sample point stalls that read.
- R6: fetch_o is 1 exactly when the registered cycle type is 2'b01. It follows the core's type one clock later and stays high through the whole cycle, including any stalled repeats.
- R7: drv_en_o is 1 only while the registered cycle is a write and dbe_i is 1. It is 0 during read cycles and whenever dbe_i is 0.
- R8: addr_o and rd_o are one-clock registered copies of the core's address and of "type is not write". They hold their values for every clock of a stalled cycle.
- R9: Only the value of rdy_i at the sample clock counts. A drop in phase one or in phase two up to the sample clock stalls the cycle. A low pulse that ends before the sample clock, or that starts after it, does not stall.
- R10: With rdy_i driven as (not fetch_o) or a step pulse, the core halts on each opcode fetch. One step pulse lets it run exactly to the next opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_type_i | input | 2 | Cycle type from the core sequencer |
| addr_i | input | ADDR_W | Address from the core sequencer |
| rdy_i | input | 1 | External ready; low stalls read cycles |
| dbe_i | input | 1 | Data-bus enable; low forces the data driver off |
| ph1_o | output | 1 | First-phase enable |
| ph2_o | output | 1 | Second-phase enable |
| adv_o | output | 1 | Core advance strobe, one per completed cycle |
| stall_o | output | 1 | Registered stall, freezes the core |
| fetch_o | output | 1 | Opcode fetch indicator |
| rd_o | output | 1 | Read strobe (0 on write cycles) |
| addr_o | output | ADDR_W | Registered bus address |
| drv_en_o | output | 1 | Data output driver enable |

## Verification
The bench targets the timing of the ready sample. It drops ready in phase one, just before the sample clock in phase two, and right after the sample. A design that sampled at the wrong clock would stall on the late pulse or miss the early drop. It also holds ready low across a write and into the following fetch: a design that stalled writes would lose the write, and one that latched the drop without re-sampling would fail to release. The dummy-read code and instruction stepping through the fetch indicator are both exercised. A block that treated the dummy code as idle, or that released for more than one instruction per pulse, would leave the stub core's cycle counter at the wrong value.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    CYC_RD    = 2'b00,
    CYC_FETCH = 2'b01,
    CYC_WR    = 2'b10,
    CYC_NOP   = 2'b11
  } cyc_e;

  function automatic logic cyc_is_rd(cyc_e t);
    return t != CYC_WR;
  endfunction
endpackage

// File: rtl/bsc_phase_gen.sv
module bsc_phase_gen #(
  parameter int PH1_LEN  = 2,
  parameter int PH2_LEN  = 2,
  parameter int RDY_TICK = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph1_o,
  output logic ph2_o,
  output logic smp_o,
  output logic last_o
);
  localparam int MAXLEN = (PH1_LEN > PH2_LEN) ? PH1_LEN : PH2_LEN;
  localparam int CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam logic [CNT_W-1:0] PH1_LAST = CNT_W'(PH1_LEN - 1);
  localparam logic [CNT_W-1:0] PH2_LAST = CNT_W'(PH2_LEN - 1);
  localparam logic [CNT_W-1:0] SMP_CNT  = CNT_W'(RDY_TICK);

  logic             ph2_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = ph2_q ? (cnt_q == PH2_LAST) : (cnt_q == PH1_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph2_q <= 1'b0;
      cnt_q <= '0;
    end else if (wrap) begin
      ph2_q <= ~ph2_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ph1_o  = ~ph2_q;
  assign ph2_o  = ph2_q;
  assign smp_o  = ph2_q && (cnt_q == SMP_CNT);
  assign last_o = ph2_q && (cnt_q == PH2_LAST);
endmodule

// File: rtl/bsc_stall.sv
module bsc_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic rd_cyc_i,
  input  logic rdy_i,
  output logic stall_o
);
  logic stall_q;

  // decision taken once per cycle at the sample tick, held until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stall_q <= 1'b0;
    else if (smp_i) stall_q <= rd_cyc_i & ~rdy_i;
  end

  assign stall_o = stall_q;

  AST_STALL_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stall_q) |-> $past(smp_i)); // R9
endmodule

// File: rtl/bsc_bus_stage.sv
module bsc_bus_stage
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dbe_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              fetch_o,
  output logic              drv_en_o
);
  cyc_e              type_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= CYC_RD;
      addr_q <= '0;
    end else begin
      type_q <= cyc_e'(cyc_type_i);
      addr_q <= addr_i;
    end
  end

  assign addr_o   = addr_q;
  assign rd_o     = cyc_is_rd(type_q);
  assign fetch_o  = (type_q == CYC_FETCH);
  assign drv_en_o = (type_q == CYC_WR) && dbe_i;

  AST_FETCH_IS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> rd_o); // R6
endmodule

// File: rtl/bus_stall_ctl.sv
module bus_stall_ctl #(
  parameter int ADDR_W   = 16,
  parameter int PH1_LEN  = 2,
  parameter int PH2_LEN  = 2,
  parameter int RDY_TICK = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rdy_i,
  input  logic              dbe_i,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              adv_o,
  output logic              stall_o,
  output logic              fetch_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              drv_en_o
);
  logic smp, last, stall;

  bsc_phase_gen #(
    .PH1_LEN (PH1_LEN),
    .PH2_LEN (PH2_LEN),
    .RDY_TICK(RDY_TICK)
  ) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph1_o (ph1_o),
    .ph2_o (ph2_o),
    .smp_o (smp),
    .last_o(last)
  );

  bsc_bus_stage #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_type_i(cyc_type_i),
    .addr_i    (addr_i),
    .dbe_i     (dbe_i),
    .addr_o    (addr_o),
    .rd_o      (rd_o),
    .fetch_o   (fetch_o),
    .drv_en_o  (drv_en_o)
  );

  bsc_stall u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (smp),
    .rd_cyc_i(rd_o),
    .rdy_i   (rdy_i),
    .stall_o (stall)
  );

  // sample tick sits before the last ph2 tick, so stall is settled here
  assign adv_o   = last & ~stall;
  assign stall_o = stall;

  AST_STALL_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> rd_o); // R5
  AST_NO_DRV_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !drv_en_o); // R7
  AST_ADV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !adv_o); // R2
  AST_STALL_HOLDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && $past(stall_o) |-> $stable(rd_o)); // R8
endmodule

// File: tb/bus_stall_ctl_tb_top.sv
module bus_stall_ctl_tb_top;
  import bsc_pkg::*;

  localparam int AW = 16;
  localparam int BASE = 'h1200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    cyc_type;
  logic [AW-1:0] addr;
  logic rdy_i, dbe_i;
  logic rdy_drv = 1'b1, step_mode = 1'b0, step_go = 1'b0, dbe_off = 1'b0;
  logic ph1, ph2, adv, stall, fetch, rd;
  logic [AW-1:0] addr_o;
  logic drv_en;

  bus_stall_ctl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_type_i(cyc_type), .addr_i(addr),
    .rdy_i(rdy_i), .dbe_i(dbe_i), .ph1_o(ph1), .ph2_o(ph2), .adv_o(adv),
    .stall_o(stall), .fetch_o(fetch), .rd_o(rd), .addr_o(addr_o), .drv_en_o(drv_en)
  );

  // stub sequencer: instructions F,R,W and F,NOP repeating
  function automatic logic [1:0] type_of(int n);
    case (n % 5)
      0, 3:    return CYC_FETCH;
      1:       return CYC_RD;
      2:       return CYC_WR;
      default: return CYC_NOP;
    endcase
  endfunction

  int cnt;
  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) cnt <= 0;
    else if (adv) cnt <= cnt + 1;

  assign cyc_type = type_of(cnt);
  assign addr     = AW'(BASE + cnt);
  assign rdy_i    = step_mode ? (!fetch || step_go) : rdy_drv;
  assign dbe_i    = ph2 & ~dbe_off;

  typedef struct packed {logic [AW-1:0] a; logic r; logic f;} item_t;
  item_t exp_q[$];
  item_t mon_e;
  int n_chk = 0, n_fail = 0, mcnt = 0;

  task automatic chk_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every advance must match the next expected completed cycle
  always @(negedge clk) begin
    if (rst_ni && adv) begin
      if (exp_q.size() == 0) chk_eq("R4 unexpected advance", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk_eq("R8 addr at advance", int'(addr_o), int'(mon_e.a));
        chk_eq("R8 rd at advance", int'(rd), int'(mon_e.r));
        chk_eq("R6 fetch at advance", int'(fetch), int'(mon_e.f));
      end
    end
  end

  // one bus cycle attempt, entered and left at the negedge of ph1 tick 0
  task automatic attempt(input logic r0, input logic r1, input logic r2,
                         input logic glitch, output logic stalled);
    logic [1:0] t;
    logic isrd, exp_rdy, exp_st;
    item_t it;
    string tag;
    t = type_of(mcnt);
    isrd = (t != CYC_WR);
    rdy_drv = r0;
    @(negedge clk);
    rdy_drv = r1;
    chk_eq("R2 ph1 high", int'(ph1), 1);
    chk_eq("R8 addr_o", int'(addr_o), BASE + mcnt);
    chk_eq("R8 rd_o", int'(rd), int'(isrd));
    chk_eq("R6 fetch_o", int'(fetch), int'(t == CYC_FETCH));
    chk_eq("R7 driver off in ph1", int'(drv_en), 0);
    @(negedge clk);
    rdy_drv = r2;
    chk_eq("R2 ph2 high", int'(ph2), 1);
    exp_rdy = step_mode ? ((t != CYC_FETCH) || step_go) : r2;
    exp_st = isrd && !exp_rdy;
    if (!exp_st) begin
      it.a = AW'(BASE + mcnt); it.r = isrd; it.f = (t == CYC_FETCH);
      exp_q.push_back(it);
    end
    @(negedge clk);
    tag = (t == CYC_WR) ? "R5 write ignores ready" :
          (step_mode ? "R10 step stall" : ((r0 != r2 || r1 != r2) ? "R9 sample point" : "R3 read stall"));
    chk_eq(tag, int'(stall), int'(exp_st));
    chk_eq("R4 advance strobe", int'(adv), int'(!exp_st));
    chk_eq("R7 driver enable", int'(drv_en), int'(t == CYC_WR && !dbe_off));
    chk_eq("R8 addr held", int'(addr_o), BASE + mcnt);
    if (!exp_st) mcnt++;
    if (glitch) rdy_drv = 1'b0;
    @(negedge clk);
    if (glitch) rdy_drv = 1'b1;
    chk_eq("R3 stub counter", cnt, mcnt);
    chk_eq("R2 back to ph1", int'(ph1), 1);
    stalled = exp_st;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic st;
    int m0, nf;
    repeat (3) @(negedge clk);
    chk_eq("R1 stall in reset", int'(stall), 0);
    chk_eq("R1 adv in reset", int'(adv), 0);
    chk_eq("R1 fetch in reset", int'(fetch), 0);
    chk_eq("R1 rd in reset", int'(rd), 1);
    chk_eq("R1 drv in reset", int'(drv_en), 0);
    chk_eq("R1 addr in reset", int'(addr_o), 0);
    chk_eq("R1 ph1 in reset", int'(ph1), 1);
    rst_ni = 1'b1;

    for (int i = 0; i < 5; i++) attempt(1, 1, 1, 0, st);   // R2 R6 R8 plain run
    attempt(0, 0, 0, 0, st);                                 // R3 fetch stalls
    attempt(0, 0, 0, 0, st);                                 // R3 repeats
    attempt(1, 1, 1, 0, st);                                 // R4 release
    attempt(0, 0, 0, 0, st);                                 // R3 read stalls
    attempt(1, 1, 1, 0, st);
    attempt(0, 0, 0, 0, st);                                 // R5 write, ready low
    attempt(0, 0, 0, 0, st);                                 // R5 deferred to fetch
    attempt(1, 1, 1, 0, st);
    attempt(0, 0, 0, 0, st);                                 // R3 dummy read stalls
    attempt(1, 1, 1, 0, st);
    attempt(0, 1, 1, 0, st);                                 // R9 early drop recovered
    attempt(1, 1, 1, 1, st);                                 // R9 pulse after sample
    attempt(1, 1, 1, 0, st);
    attempt(1, 0, 0, 0, st);                                 // R9 drop in ph1 counts
    attempt(1, 1, 1, 0, st);
    attempt(1, 1, 0, 0, st);                                 // R9 drop in ph2 before sample
    attempt(1, 1, 1, 0, st);
    dbe_off = 1'b1;                                          // R7 driver forced off
    for (int i = 0; i < 5; i++) attempt(1, 1, 1, 0, st);
    dbe_off = 1'b0;

    step_mode = 1'b1;                                        // R10 stepping
    st = 1'b0;
    for (int i = 0; i < 6 && !st; i++) attempt(1, 1, 1, 0, st);
    chk_eq("R10 halted on fetch", int'(type_of(mcnt) == CYC_FETCH), 1);
    for (int s = 0; s < 2; s++) begin
      m0 = mcnt;
      nf = m0 + 1;
      while (type_of(nf) != CYC_FETCH) nf++;
      step_go = 1'b1;
      attempt(1, 1, 1, 0, st);
      step_go = 1'b0;
      st = 1'b0;
      for (int i = 0; i < 8 && !st; i++) attempt(1, 1, 1, 0, st);
      chk_eq("R10 one instruction per step", cnt, nf);
    end
    step_mode = 1'b0;
    attempt(1, 1, 1, 0, st);

    chk_eq("R4 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule